// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events and clock cycles for profiling. It has a configurable number of 32-bit event counters and one 32-bit cycle counter. Each event counter watches one bit of an event pulse vector and adds one in every clock cycle where that bit is high. The cycle counter adds one on every clock. A counter runs only while the unit-wide run bit and its own enable bit are both set.

Software uses a simple word-addressed read/write port. Enables for counting and for interrupts are changed through separate set and clear addresses, so one counter can be changed without a read-modify-write. Overflow flags are sticky and are cleared by writing a one. Event counters are reached through an index register, while the cycle counter has its own data address. Software can write any counter, so it can preload a value a known distance below the wrap point and take an interrupt after a chosen number of events.

Top module: `perfmon_unit`

## Requirements
- R1: After a synchronous reset, every counter, enable mask, overflow flag, the index register and the run bit are zero. `irq` is low, and address 0 reads back the event counter count in bits 15:11.
- R2: Address 0 is control. Bit 0 is the run bit and can be read and written. Bits 15:11 always read the number of event counters, and writes to them have no effect. All other bits read zero.
- R3: An event counter advances only when the run bit and its own count-enable bit are both 1. The cycle counter (address 9) advances by one on each clock while the run bit and count-enable bit 31 are both 1.
- R4: Count enable is set by writing address 1 and cleared by writing address 2. Interrupt enable is set by writing address 3 and cleared by writing address 4. A 1 in bit n acts on counter n and a 0 bit has no effect. Both addresses of a pair read the current mask. Only bits 0..N-1 (event counters) and bit 31 (cycle counter) exist; the other bits read zero.
- R5: Address 6 holds a counter index. Addresses 7 (counter value) and 8 (event type) act on the counter at that index. If the index is N or larger, both addresses read zero and writes to them are dropped.
- R6: An event counter adds one in each cycle where event input bit `type` is high. A type value at or above the event vector width never counts.
- R7: When a counter steps from 0xFFFFFFFF to 0, its overflow flag is set: bit n for event counter n, bit 31 for the cycle counter. Flags are read at address 5 and stay set until a 1 is written to that bit; writing 0 leaves the flag as it is.
- R8: `irq` is a registered level. One cycle after any bit of (overflow AND interrupt enable) is 1, `irq` is high. It falls one cycle after that product becomes zero.
- R9: A software write to a counter wins over an increment in the same cycle. A wrap that sets a flag wins over a write-one clear of that flag in the same cycle.
- R10: A read issued with `rd_en` in one cycle presents its data on `rdata` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_in | input | EVT_IN_W | Event pulse inputs, one bit per event source |
| irq | output | 1 | Level interrupt on an enabled overflow |

## Verification
The bench aims at the cycle where a preloaded counter crosses 0xFFFFFFFF. A design that wraps without flagging, or that flags one step early or late, reads back the wrong count or flag.

Same-cycle collisions are driven on purpose: a counter write while the counter runs, and a clear of the cycle flag in the same cycle as the wrap. A design that lets the increment win returns the written value plus one. A design that lets the clear win loses the overflow.

Out-of-range indices and event types are also used. An unguarded decode would write into a real counter or count an unrelated input. Zero bits in the set, clear and status writes must leave the masks unchanged; a design that treats them as plain writes wipes enables that are already on.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int REG_AW       = 4;
  localparam int WORD_W       = 32;
  localparam int CYC_BIT      = 31;
  localparam int NFIELD_LSB   = 11;
  localparam int NFIELD_W     = 5;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL    = 4'd0,
    RA_CEN_SET = 4'd1,
    RA_CEN_CLR = 4'd2,
    RA_IEN_SET = 4'd3,
    RA_IEN_CLR = 4'd4,
    RA_OVF     = 4'd5,
    RA_INDEX   = 4'd6,
    RA_EVDATA  = 4'd7,
    RA_EVTYPE  = 4'd8,
    RA_CYCLE   = 4'd9
  } reg_addr_e;

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);

  logic [W-1:0] cnt_q;

  // a software load takes priority over a same-cycle increment
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign value = cnt_q;
  assign wrap  = inc && !load && (cnt_q == {W{1'b1}});

endmodule

// File: rtl/perfmon_evt_pick.sv
module perfmon_evt_pick #(
  parameter int IN_W   = 16,
  parameter int TYPE_W = 8
) (
  input  logic [IN_W-1:0]   evt_in,
  input  logic [TYPE_W-1:0] evt_type,
  output logic              hit
);

  localparam int IDX_W = (IN_W > 1) ? $clog2(IN_W) : 1;

  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx      = evt_type[IDX_W-1:0];
  assign in_range = (32'(evt_type) < IN_W);
  assign hit      = in_range && evt_in[idx];

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int EVT_IN_W = 16,
  parameter int TYPE_W   = 8,
  parameter int SEL_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  input  logic [EVT_IN_W-1:0] evt_in,
  output logic                irq
);

  localparam int IDXW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [WORD_W-1:0] EVT_MASK  = WORD_W'((64'd1 << NUM_EVT) - 64'd1);
  localparam logic [WORD_W-1:0] IMPL_MASK = EVT_MASK | (WORD_W'(1) << CYC_BIT);

  logic                gen_q;
  logic [WORD_W-1:0]   cen_q, ien_q, ovf_q;
  logic [SEL_W-1:0]    sel_q;
  logic [TYPE_W-1:0]   type_q [NUM_EVT];
  logic [WORD_W-1:0]   evt_val [NUM_EVT];
  logic [NUM_EVT-1:0]  evt_wrap;
  logic [WORD_W-1:0]   cyc_val;
  logic                cyc_wrap;
  logic [WORD_W-1:0]   wrap_vec;
  logic [WORD_W-1:0]   rd_mux;
  logic [WORD_W-1:0]   rdata_q;
  logic                irq_q;
  logic                sel_ok;
  logic [IDXW-1:0]     sel_idx;

  assign sel_ok  = (32'(sel_q) < NUM_EVT);
  assign sel_idx = sel_q[IDXW-1:0];

  // event counters, each with its own source picker and type register
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic hit, ld, ty_wr;

    assign ld    = wr_en && (addr == RA_EVDATA) && sel_ok && (32'(sel_q) == i);
    assign ty_wr = wr_en && (addr == RA_EVTYPE) && sel_ok && (32'(sel_q) == i);

    always_ff @(posedge clk) begin
      if (rst)        type_q[i] <= '0;
      else if (ty_wr) type_q[i] <= wdata[TYPE_W-1:0];
    end

    perfmon_evt_pick #(.IN_W(EVT_IN_W), .TYPE_W(TYPE_W)) u_pick (
      .evt_in  (evt_in),
      .evt_type(type_q[i]),
      .hit     (hit)
    );

    perfmon_counter #(.W(WORD_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .load    (ld),
      .load_val(wdata),
      .inc     (gen_q && cen_q[i] && hit),
      .value   (evt_val[i]),
      .wrap    (evt_wrap[i])
    );
  end

  perfmon_counter #(.W(WORD_W)) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .load    (wr_en && (addr == RA_CYCLE)),
    .load_val(wdata),
    .inc     (gen_q && cen_q[CYC_BIT]),
    .value   (cyc_val),
    .wrap    (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_EVT; i++) wrap_vec[i] = evt_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  // control, enables, index and sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= 1'b0;
      cen_q <= '0;
      ien_q <= '0;
      ovf_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_en && addr == RA_CTRL)    gen_q <= wdata[0];
      if (wr_en && addr == RA_CEN_SET) cen_q <= cen_q | (wdata & IMPL_MASK);
      if (wr_en && addr == RA_CEN_CLR) cen_q <= cen_q & ~wdata;
      if (wr_en && addr == RA_IEN_SET) ien_q <= ien_q | (wdata & IMPL_MASK);
      if (wr_en && addr == RA_IEN_CLR) ien_q <= ien_q & ~wdata;
      if (wr_en && addr == RA_INDEX)   sel_q <= wdata[SEL_W-1:0];
      // a wrap in the same cycle beats the write-one clear
      ovf_q <= ((wr_en && addr == RA_OVF) ? (ovf_q & ~wdata) : ovf_q) | wrap_vec;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL:    begin
                    rd_mux[0] = gen_q;
                    rd_mux[NFIELD_LSB +: NFIELD_W] = NFIELD_W'(NUM_EVT);
                  end
      RA_CEN_SET,
      RA_CEN_CLR: rd_mux = cen_q;
      RA_IEN_SET,
      RA_IEN_CLR: rd_mux = ien_q;
      RA_OVF:     rd_mux = ovf_q;
      RA_INDEX:   rd_mux = WORD_W'(sel_q);
      RA_EVDATA:  if (sel_ok) rd_mux = evt_val[sel_idx];
      RA_EVTYPE:  if (sel_ok) rd_mux = WORD_W'(type_q[sel_idx]);
      RA_CYCLE:   rd_mux = cyc_val;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= |(ovf_q & ien_q);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [31:0] wdata,
  input logic        irq,
  input logic        gen_q,
  input logic [31:0] cen_q,
  input logic [31:0] ien_q,
  input logic [31:0] ovf_q,
  input logic [31:0] cyc_val
);

  logic cyc_wr;
  logic ovf31_clr;
  assign cyc_wr    = wr_en && (addr == 4'd9);
  assign ovf31_clr = wr_en && (addr == 4'd5) && wdata[31];

  // R8: irq is the registered OR of enabled flags
  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|$past(ovf_q & ien_q))));

  // R7: the cycle flag holds unless a one is written to it
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q[31] && !ovf31_clr) |=> ovf_q[31]);

  // R3: with the run bit off, the cycle counter holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!gen_q && !cyc_wr) |=> $stable(cyc_val));

  // R3: with run bit and bit 31 enabled, one step per clock
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (rst)
    (gen_q && cen_q[31] && !cyc_wr) |=> (cyc_val == $past(cyc_val) + 32'd1));

  // R9: a counter write beats the increment
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    cyc_wr |=> (cyc_val == $past(wdata)));

  // R9: a wrap beats a same-cycle clear of the flag
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (gen_q && cen_q[31] && !cyc_wr && cyc_val == 32'hFFFF_FFFF) |=> ovf_q[31]);

endmodule

bind perfmon_unit perfmon_unit_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .irq    (irq),
  .gen_q  (gen_q),
  .cen_q  (cen_q),
  .ien_q  (ien_q),
  .ovf_q  (ovf_q),
  .cyc_val(cyc_val)
);

// File: tb/perfmon_unit_bench.sv
`timescale 1ns/1ps
module perfmon_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] evt_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perfmon_unit u_perfmon_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic quiesce();
    wr(4'd0, 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd0, d);  check("R1 ctrl", d, 32'h0000_2000);
    rd(4'd1, d);  check("R1 cen", d, 32'd0);
    rd(4'd5, d);  check("R1 ovf", d, 32'd0);
    rd(4'd9, d);  check("R1 cycle", d, 32'd0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d);  check("R2 ctrl all ones", d, 32'h0000_2001);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, d);  check("R2 ctrl zero (R10 read)", d, 32'h0000_2000);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    quiesce();
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d);  check("R4 cen set", d, 32'h8000_000F);
    wr(4'd2, 32'h0000_0005);
    rd(4'd2, d);  check("R4 cen clr", d, 32'h8000_000A);
    wr(4'd1, 32'h0000_0000);
    rd(4'd1, d);  check("R4 zero set no effect", d, 32'h8000_000A);
    wr(4'd3, 32'h8000_0002);
    wr(4'd4, 32'h0000_0000);
    rd(4'd4, d);  check("R4 ien pair", d, 32'h8000_0002);
  endtask

  task automatic t_cycle();
    logic [31:0] d;
    quiesce();
    wr(4'd9, 32'd100);
    wr(4'd1, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rd(4'd9, d);  check("R3 no run bit no count", d, 32'd100);
    wr(4'd0, 32'd1);
    repeat (5) @(negedge clk);
    wr(4'd0, 32'd0);
    rd(4'd9, d);  check("R3 cycle count", d, 32'd106);
  endtask

  task automatic t_events();
    logic [31:0] d;
    quiesce();
    wr(4'd6, 32'd0); wr(4'd8, 32'd2); wr(4'd7, 32'd0);
    wr(4'd6, 32'd1); wr(4'd8, 32'd3); wr(4'd7, 32'd0);
    wr(4'd6, 32'd2); wr(4'd8, 32'd3); wr(4'd7, 32'd0);
    wr(4'd6, 32'd3); wr(4'd8, 32'd200); wr(4'd7, 32'd0);
    wr(4'd1, 32'h0000_000B);
    wr(4'd0, 32'd1);
    evt_in = 16'hFFF0 | 16'h000C;
    @(negedge clk);
    evt_in = 16'hFFF8;
    repeat (3) @(negedge clk);
    evt_in = 16'h0000;
    wr(4'd0, 32'd0);
    evt_in = 16'h0008;
    repeat (3) @(negedge clk);
    evt_in = 16'h0000;
    wr(4'd6, 32'd0); rd(4'd7, d); check("R6 ctr0 type 2", d, 32'd1);
    wr(4'd6, 32'd1); rd(4'd7, d); check("R6 ctr1 type 3 (R3 idle hold)", d, 32'd4);
    wr(4'd6, 32'd2); rd(4'd7, d); check("R3 disabled ctr2", d, 32'd0);
    wr(4'd6, 32'd3); rd(4'd7, d); check("R6 type out of range", d, 32'd0);
    rd(4'd8, d);                  check("R5 type readback", d, 32'd200);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(4'd6, 32'd7);
    wr(4'd7, 32'h1234_5678);
    wr(4'd8, 32'd5);
    rd(4'd6, d);  check("R5 index readback", d, 32'd7);
    rd(4'd7, d);  check("R5 bad index data", d, 32'd0);
    rd(4'd8, d);  check("R5 bad index type", d, 32'd0);
    wr(4'd6, 32'd3);
    rd(4'd7, d);  check("R5 bad write dropped", d, 32'd0);
    rd(4'd8, d);  check("R5 bad type write dropped", d, 32'd200);
  endtask

  task automatic t_overflow_irq();
    logic [31:0] d;
    quiesce();
    wr(4'd6, 32'd0); wr(4'd8, 32'd2); wr(4'd7, 32'hFFFF_FFFE);
    wr(4'd1, 32'h0000_0001);
    wr(4'd3, 32'h0000_0001);
    wr(4'd0, 32'd1);
    evt_in = 16'h0004;
    repeat (3) @(negedge clk);
    evt_in = 16'h0000;
    wr(4'd0, 32'd0);
    rd(4'd7, d);  check("R7 wrapped value", d, 32'd1);
    rd(4'd5, d);  check("R7 flag set", d, 32'h0000_0001);
    check("R8 irq high", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'h0000_0000);
    rd(4'd5, d);  check("R7 zero write keeps flag", d, 32'h0000_0001);
    wr(4'd4, 32'h0000_0001);
    @(negedge clk);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h0000_0001);
    @(negedge clk);
    check("R8 irq back", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'h0000_0001);
    @(negedge clk);
    check("R8 irq drops after clear", {31'd0, irq}, 32'd0);
    rd(4'd5, d);  check("R7 flag cleared", d, 32'd0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    quiesce();
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'd1);
    wr(4'd9, 32'd500);
    rd(4'd9, d);  check("R9 write beats increment", d, 32'd500);
    wr(4'd9, 32'hFFFF_FFFE);
    @(negedge clk);
    wr(4'd5, 32'h8000_0000);
    wr(4'd0, 32'd0);
    rd(4'd5, d);  check("R9 set beats clear", d, 32'h8000_0000);
    rd(4'd9, d);  check("R7 cycle wrapped", d, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_masks();
    t_cycle();
    t_events();
    t_select();
    t_overflow_irq();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule